// File: doc/BRIEF.md
# I3C Broadcast Common-Command Write Sequencer

This block takes one transfer descriptor at a time from a command port and plays out a broadcast Common Command Code (CCC) write on an I3C bus. It does not drive the bus pins. It drives a byte-level bus engine through a request/done handshake with four operations: START, address byte with acknowledge, data byte with T-bit, and STOP. The payload comes from one of two sources. It is either read from a show-ahead transmit FIFO, or taken from up to four immediate bytes held inside the descriptor itself.

Each accepted descriptor produces exactly one response word. The response carries an error status and the number of payload bytes that went out. If the broadcast address header is not acknowledged, the block issues STOP, reports the error, and then refuses further descriptors until a resume pulse arrives.

Descriptor layout (64 bits):

| Bits | Meaning |
|---|---|
| 0 | payload source: 0 = FIFO, 1 = immediate |
| 3 | descriptor valid flag |
| 13:7 | CCC code |
| 14 | 1 = directed |
| 20:15 | target index |
| 23:21 | speed mode |
| 24 | read flag |
| 27:25 | immediate byte count |
| 47:32 | FIFO payload length |
| 63:32 | immediate bytes, lowest byte at 39:32 |

Response word: bits 3:0 hold the status (0 ok, 1 address NACK, 2 rejected descriptor), bits 15:4 are zero, and bits 31:16 hold the count of payload bytes sent.

Top module: `i3c_bccc_seq`

## Requirements
- R1: A descriptor accepted with bit 3 at 0 is discarded. It causes no bus operation and no response.
- R2: A valid broadcast write issues these operations in order: START (op 0); address byte 0xFC, which is 0x7E with the write bit (op 1); the CCC byte, which is {0, bits 13:7} (op 2); the payload bytes (op 2); and STOP (op 3).
- R3: Every op-2 byte carries a T-bit that gives the byte plus T-bit an odd count of ones. The address operation drives T-bit 0.
- R4: In FIFO mode (bit 0 = 0), exactly bits 47:32 bytes are popped and sent in FIFO order. While the FIFO is empty the block waits and does not pop.
- R5: In immediate mode (bit 0 = 1), bits 27:25 bytes are sent from bits 63:32, lowest byte first. The target index in bits 20:15 has no effect on the bytes sent.
- R6: A length or count of zero sends only START, address, CCC byte and STOP. The response reports 0 bytes.
- R7: An address NACK is followed by STOP and a response with status 1 and count 0. After that, cmd_ready stays low until a resume pulse, and a command offered meanwhile starts no bus operation.
- R8: A descriptor with bit 24 set, a nonzero bits 23:21, or bit 14 set is answered with status 2 and count 0, and no bus operation.
- R9: Exactly one response is pushed per descriptor that bit 3 validates. After a successful transfer it holds status 0 and the byte count. While resp_full is high, the response is held stable with resp_push asserted.
- R10: An immediate count above 4 sends the four bytes and then stalls. It issues no STOP and no response, and the stall lasts until reset.
- R11: Once bus_req rises, bus_op, bus_byte and bus_tbit stay stable until bus_done.
- R12: After reset, cmd_ready is high and bus_req, resp_push and tx_pop are low. cmd_ready is high only when no bus request and no response are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | descriptor offered |
| cmd_ready | output | 1 | descriptor taken when both high |
| cmd_word | input | 64 | transfer descriptor |
| tx_empty | input | 1 | transmit FIFO has no data |
| tx_data | input | 8 | head byte of transmit FIFO |
| tx_pop | output | 1 | consume head byte |
| bus_req | output | 1 | operation requested from bus engine |
| bus_op | output | 2 | 0 START, 1 address, 2 data byte, 3 STOP |
| bus_byte | output | 8 | byte for address or data operation |
| bus_tbit | output | 1 | T-bit for data operation |
| bus_done | input | 1 | one-cycle completion pulse from engine |
| bus_nack | input | 1 | acknowledge missing, valid with bus_done |
| resp_push | output | 1 | response write request |
| resp_word | output | 32 | response contents |
| resp_full | input | 1 | response FIFO cannot accept |
| resume | input | 1 | leave halted state |

## Verification
The assertions rely on the bus engine behaving as follows:
- It raises bus_done for one cycle only while a request is up.
- It lowers bus_done in the next cycle.
- It reports bus_nack only together with bus_done.

They also rely on tx_data being valid whenever tx_empty is low. The bench bus model meets all of this: it counts a fixed delay per request, pulses done once and clears it the following edge, and drives NACK only on a chosen address operation. The FIFO model presents its head entry continuously and advances only on tx_pop. resume and resp_full are driven between clock edges and held for whole cycles.

// File: rtl/i3c_bccc_pkg.sv
package i3c_bccc_pkg;

  typedef enum logic [1:0] {
    BOP_START = 2'd0,
    BOP_ADDR  = 2'd1,
    BOP_DATA  = 2'd2,
    BOP_STOP  = 2'd3
  } bus_op_e;

  localparam logic [3:0] ST_OK        = 4'd0;
  localparam logic [3:0] ST_ADDR_NACK = 4'd1;
  localparam logic [3:0] ST_REJECT    = 4'd2;

  localparam logic [6:0] BCAST_ADDR = 7'h7E;

  typedef struct packed {
    logic        present;
    logic        directed;
    logic [6:0]  ccc;
    logic [2:0]  mode;
    logic        rd;
    logic        imm;
    logic [2:0]  imm_cnt;
    logic [15:0] len;
    logic [31:0] imm_data;
  } desc_t;

  function automatic logic odd_tbit(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [7:0] hdr_byte();
    return {BCAST_ADDR, 1'b0};
  endfunction

  function automatic logic [7:0] ccc_byte(input logic [6:0] code);
    return {1'b0, code};
  endfunction

  function automatic logic rejected(input desc_t d);
    return d.directed | d.rd | (d.mode != 3'd0);
  endfunction

endpackage

// File: rtl/i3c_bccc_decode.sv
module i3c_bccc_decode
  import i3c_bccc_pkg::*;
#(
  parameter int CMD_W = 64
) (
  input  logic [CMD_W-1:0] cmd_word,
  output desc_t            desc,
  output logic             reject
);
  always_comb begin
    desc.imm      = cmd_word[0];
    desc.present  = cmd_word[3];
    desc.ccc      = cmd_word[13:7];
    desc.directed = cmd_word[14];
    desc.mode     = cmd_word[23:21];
    desc.rd       = cmd_word[24];
    desc.imm_cnt  = cmd_word[27:25];
    desc.len      = cmd_word[47:32];
    desc.imm_data = cmd_word[63:32];
  end

  assign reject = rejected(desc);
endmodule

// File: rtl/i3c_bccc_payload.sv
module i3c_bccc_payload #(
  parameter int LEN_W     = 16,
  parameter int IMM_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   load_imm,
  input  logic [LEN_W-1:0]       load_len,
  input  logic [8*IMM_BYTES-1:0] load_data,
  input  logic                   fetch,
  input  logic                   advance,
  input  logic                   tx_empty,
  input  logic [7:0]             tx_data,
  output logic                   tx_pop,
  output logic                   avail,
  output logic [7:0]             cur_byte,
  output logic                   none,
  output logic                   last,
  output logic [LEN_W-1:0]       sent
);
  localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1;
  localparam logic [LEN_W-1:0] IMM_LIM = LEN_W'(IMM_BYTES);

  logic                   imm_q;
  logic [LEN_W-1:0]       len_q;
  logic [8*IMM_BYTES-1:0] imm_data_q;
  logic [LEN_W-1:0]       sent_q;
  logic [7:0]             byte_q;
  logic [7:0]             imm_b [IMM_BYTES];
  logic [LEN_W-1:0]       sent_nx;

  for (genvar g = 0; g < IMM_BYTES; g++) begin : g_unpack
    assign imm_b[g] = imm_data_q[8*g +: 8];
  end

  assign sent_nx = sent_q + 1'b1;
  assign avail   = imm_q ? (sent_q < IMM_LIM) : !tx_empty;
  assign tx_pop  = fetch && !imm_q && !tx_empty;
  assign none    = (len_q == '0);
  assign last    = (sent_nx == len_q);
  assign sent    = sent_q;
  assign cur_byte = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      imm_q      <= 1'b0;
      len_q      <= '0;
      imm_data_q <= '0;
      sent_q     <= '0;
      byte_q     <= '0;
    end else begin
      if (load) begin
        imm_q      <= load_imm;
        len_q      <= load_len;
        imm_data_q <= load_data;
        sent_q     <= '0;
      end else if (advance) begin
        sent_q <= sent_nx;
      end
      if (fetch && avail)
        byte_q <= imm_q ? imm_b[sent_q[IDX_W-1:0]] : tx_data;
    end
  end
endmodule

// File: rtl/i3c_bccc_seq.sv
module i3c_bccc_seq
  import i3c_bccc_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int IMM_BYTES = 4,
  parameter int CMD_W     = 64,
  parameter int STAT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [CMD_W-1:0]          cmd_word,
  input  logic                      tx_empty,
  input  logic [7:0]                tx_data,
  output logic                      tx_pop,
  output logic                      bus_req,
  output logic [1:0]                bus_op,
  output logic [7:0]                bus_byte,
  output logic                      bus_tbit,
  input  logic                      bus_done,
  input  logic                      bus_nack,
  output logic                      resp_push,
  output logic [LEN_W+16-1:0]       resp_word,
  input  logic                      resp_full,
  input  logic                      resume
);
  localparam int PAD_W = 16 - STAT_W;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_CCC, S_FETCH, S_DATA, S_STOP, S_RESP, S_HALT
  } state_e;

  state_e              st;
  logic [6:0]          ccc_q;
  logic [STAT_W-1:0]   stat_q;
  logic                halt_pend;

  desc_t               desc;
  logic                reject;
  logic [LEN_W-1:0]    eff_len;

  logic                pay_avail;
  logic [7:0]          pay_byte;
  logic                pay_none;
  logic                pay_last;
  logic [LEN_W-1:0]    pay_sent;

  // named events for the checker
  logic ev_accept;
  logic ev_halted;
  logic ev_addr_nack;
  logic ev_byte_sent;
  logic ev_fetch;

  i3c_bccc_decode #(.CMD_W(CMD_W)) u_dec (
    .cmd_word (cmd_word),
    .desc     (desc),
    .reject   (reject)
  );

  assign eff_len = desc.imm ? LEN_W'(desc.imm_cnt) : LEN_W'(desc.len);

  assign cmd_ready    = (st == S_IDLE);
  assign ev_accept    = cmd_valid && cmd_ready;
  assign ev_halted    = (st == S_HALT);
  assign ev_addr_nack = (st == S_ADDR) && bus_done && bus_nack;
  assign ev_byte_sent = (st == S_DATA) && bus_done;
  assign ev_fetch     = (st == S_FETCH);

  i3c_bccc_payload #(.LEN_W(LEN_W), .IMM_BYTES(IMM_BYTES)) u_pay (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ev_accept),
    .load_imm  (desc.imm),
    .load_len  (eff_len),
    .load_data (desc.imm_data[8*IMM_BYTES-1:0]),
    .fetch     (ev_fetch),
    .advance   (ev_byte_sent),
    .tx_empty  (tx_empty),
    .tx_data   (tx_data),
    .tx_pop    (tx_pop),
    .avail     (pay_avail),
    .cur_byte  (pay_byte),
    .none      (pay_none),
    .last      (pay_last),
    .sent      (pay_sent)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ccc_q     <= '0;
      stat_q    <= ST_OK;
      halt_pend <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (ev_accept && desc.present) begin
          halt_pend <= 1'b0;
          ccc_q     <= desc.ccc;
          if (reject) begin
            stat_q <= ST_REJECT;
            st     <= S_RESP;
          end else begin
            stat_q <= ST_OK;
            st     <= S_START;
          end
        end
        S_START: if (bus_done) st <= S_ADDR;
        S_ADDR: if (bus_done) begin
          if (bus_nack) begin
            stat_q    <= ST_ADDR_NACK;
            halt_pend <= 1'b1;
            st        <= S_STOP;
          end else begin
            st <= S_CCC;
          end
        end
        S_CCC:   if (bus_done) st <= pay_none ? S_STOP : S_FETCH;
        S_FETCH: if (pay_avail) st <= S_DATA;
        S_DATA:  if (bus_done) st <= pay_last ? S_STOP : S_FETCH;
        S_STOP:  if (bus_done) st <= S_RESP;
        S_RESP:  if (!resp_full) st <= halt_pend ? S_HALT : S_IDLE;
        S_HALT:  if (resume) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req  = 1'b0;
    bus_op   = BOP_START;
    bus_byte = 8'h00;
    unique case (st)
      S_START: begin bus_req = 1'b1; bus_op = BOP_START; end
      S_ADDR:  begin bus_req = 1'b1; bus_op = BOP_ADDR; bus_byte = hdr_byte(); end
      S_CCC:   begin bus_req = 1'b1; bus_op = BOP_DATA; bus_byte = ccc_byte(ccc_q); end
      S_DATA:  begin bus_req = 1'b1; bus_op = BOP_DATA; bus_byte = pay_byte; end
      S_STOP:  begin bus_req = 1'b1; bus_op = BOP_STOP; end
      default: ;
    endcase
  end

  assign bus_tbit  = (bus_op == BOP_DATA) ? odd_tbit(bus_byte) : 1'b0;
  assign resp_push = (st == S_RESP);
  assign resp_word = {pay_sent, {PAD_W{1'b0}}, stat_q};
endmodule

// File: rtl/i3c_bccc_checker.sv
module i3c_bccc_checker #(
  parameter int RESP_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              tx_empty,
  input logic              tx_pop,
  input logic              bus_req,
  input logic [1:0]        bus_op,
  input logic [7:0]        bus_byte,
  input logic              bus_tbit,
  input logic              bus_done,
  input logic              resp_push,
  input logic [RESP_W-1:0] resp_word,
  input logic              resp_full,
  input logic              resume,
  input logic              ev_halted,
  input logic              ev_addr_nack
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_done |=> bus_req && $stable(bus_op) && $stable(bus_byte) && $stable(bus_tbit));

  assert_nack_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_addr_nack |=> bus_req && bus_op == 2'd3);

  assert_halt_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halted && !resume |=> !cmd_ready);

  assert_push_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_push && resp_full |=> resp_push && $stable(resp_word));

  assert_single_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_push && !resp_full |=> !resp_push);

  assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> !tx_empty);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !bus_req && !resp_push);

  assert_tbit_odd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_op == 2'd2 |-> ($countones({bus_byte, bus_tbit}) % 2) == 1);
endmodule

bind i3c_bccc_seq i3c_bccc_checker #(.RESP_W(LEN_W + 16)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_ready    (cmd_ready),
  .tx_empty     (tx_empty),
  .tx_pop       (tx_pop),
  .bus_req      (bus_req),
  .bus_op       (bus_op),
  .bus_byte     (bus_byte),
  .bus_tbit     (bus_tbit),
  .bus_done     (bus_done),
  .resp_push    (resp_push),
  .resp_word    (resp_word),
  .resp_full    (resp_full),
  .resume       (resume),
  .ev_halted    (ev_halted),
  .ev_addr_nack (ev_addr_nack)
);

// File: tb/i3c_bccc_seq_bench.sv
module i3c_bccc_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [63:0] cmd_word = '0;
  logic        tx_empty;
  logic [7:0]  tx_data;
  logic        tx_pop;
  logic        bus_req;
  logic [1:0]  bus_op;
  logic [7:0]  bus_byte;
  logic        bus_tbit;
  logic        bus_done = 1'b0;
  logic        bus_nack = 1'b0;
  logic        resp_push;
  logic [31:0] resp_word;
  logic        resp_full = 1'b0;
  logic        resume = 1'b0;

  always #5 clk = ~clk;

  i3c_bccc_seq u_i3c_bccc_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
    .bus_req(bus_req), .bus_op(bus_op), .bus_byte(bus_byte), .bus_tbit(bus_tbit),
    .bus_done(bus_done), .bus_nack(bus_nack), .resp_push(resp_push),
    .resp_word(resp_word), .resp_full(resp_full), .resume(resume)
  );

  int errs = 0;
  int checks = 0;
  int ev_n = 0;
  int resp_n = 0;
  logic nack_next = 1'b0;

  logic [10:0] exp_bus[$];
  logic [19:0] exp_resp[$];

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // transmit FIFO model
  logic [7:0] txm [0:63];
  int tx_wr = 0;
  int tx_rd = 0;
  assign tx_empty = (tx_wr == tx_rd);
  assign tx_data  = txm[tx_rd[5:0]];
  always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

  task automatic tx_put(input logic [7:0] b);
    txm[tx_wr[5:0]] = b;
    tx_wr = tx_wr + 1;
  endtask

  // bus engine model and bus monitor
  int eng_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_done <= 1'b0;
      bus_nack <= 1'b0;
      eng_cnt  <= 0;
    end else if (bus_done) begin
      bus_done <= 1'b0;
      bus_nack <= 1'b0;
    end else if (bus_req) begin
      if (eng_cnt == 2) begin
        logic [10:0] got;
        eng_cnt  <= 0;
        bus_done <= 1'b1;
        bus_nack <= (bus_op == 2'd1) && nack_next;
        got = {bus_op, bus_byte, bus_tbit};
        ev_n++;
        if (exp_bus.size() == 0) begin
          check(1'b0, "R2 unexpected bus op", longint'(got), 0);
        end else begin
          logic [10:0] e;
          e = exp_bus.pop_front();
          check(got == e, "R2/R3/R4/R5 bus op {op,byte,tbit}", longint'(got), longint'(e));
        end
      end else begin
        eng_cnt <= eng_cnt + 1;
      end
    end
  end

  // response monitor
  always @(posedge clk) begin
    if (rst_n && resp_push && !resp_full) begin
      logic [19:0] got;
      got = {resp_word[31:16], resp_word[3:0]};
      resp_n++;
      if (exp_resp.size() == 0) begin
        check(1'b0, "R9 unexpected response", longint'(got), 0);
      end else begin
        logic [19:0] e;
        e = exp_resp.pop_front();
        check(got == e, "R9 response {count,status}", longint'(got), longint'(e));
      end
    end
  end

  function automatic bit tb_tbit(input logic [7:0] b);
    return ($countones(b) % 2) == 0;
  endfunction

  task automatic exp_data(input logic [7:0] b);
    exp_bus.push_back({2'd2, b, tb_tbit(b)});
  endtask

  task automatic exp_head(input logic [6:0] code);
    exp_bus.push_back({2'd0, 8'h00, 1'b0});
    exp_bus.push_back({2'd1, 8'hFC, 1'b0});
    exp_data({1'b0, code});
  endtask

  task automatic exp_stop();
    exp_bus.push_back({2'd3, 8'h00, 1'b0});
  endtask

  task automatic exp_rsp(input logic [3:0] st, input logic [15:0] n);
    exp_resp.push_back({n, st});
  endtask

  function automatic logic [63:0] mk(input bit present, input bit imm, input logic [6:0] code,
                                     input bit dir, input logic [5:0] tgt, input logic [2:0] mode,
                                     input bit rd, input logic [2:0] cnt, input logic [31:0] hi);
    logic [63:0] w;
    w = '0;
    w[0] = imm; w[3] = present; w[13:7] = code; w[14] = dir; w[20:15] = tgt;
    w[23:21] = mode; w[24] = rd; w[27:25] = cnt; w[63:32] = hi;
    return w;
  endfunction

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_bus.size() != 0 || exp_resp.size() != 0 || !cmd_ready) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int e0;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(cmd_ready == 1'b1, "R12 cmd_ready after reset", cmd_ready, 1);
    check(!bus_req && !resp_push && !tx_pop, "R12 outputs quiet after reset",
          {bus_req, resp_push, tx_pop}, 0);

    // R1 descriptor without valid flag
    e0 = ev_n; r0 = resp_n;
    send(mk(0, 1, 7'h01, 0, 0, 0, 0, 3'd2, 32'h1234_5678));
    repeat (20) @(negedge clk);
    check(ev_n == e0 && resp_n == r0, "R1 no activity", ev_n - e0 + resp_n - r0, 0);
    check(cmd_ready == 1'b1, "R1 ready again", cmd_ready, 1);

    // R2 R3 R5 immediate three bytes, target index set
    exp_head(7'h01); exp_data(8'hD4); exp_data(8'hC3); exp_data(8'hB2); exp_stop();
    exp_rsp(4'd0, 16'd3);
    send(mk(1, 1, 7'h01, 0, 6'h2A, 0, 0, 3'd3, 32'hA1B2_C3D4));
    drain();

    // R5 four immediate bytes
    exp_head(7'h7F); exp_data(8'h44); exp_data(8'h33); exp_data(8'h22); exp_data(8'h11); exp_stop();
    exp_rsp(4'd0, 16'd4);
    send(mk(1, 1, 7'h7F, 0, 6'h00, 0, 0, 3'd4, 32'h1122_3344));
    drain();

    // R6 zero count, immediate and FIFO
    exp_head(7'h06); exp_stop(); exp_rsp(4'd0, 16'd0);
    send(mk(1, 1, 7'h06, 0, 0, 0, 0, 3'd0, 32'hFFFF_FFFF));
    drain();
    exp_head(7'h00); exp_stop(); exp_rsp(4'd0, 16'd0);
    send(mk(1, 0, 7'h00, 0, 0, 0, 0, 3'd0, 32'h0000_0000));
    drain();

    // R4 FIFO payload with an empty gap
    tx_put(8'h5A); tx_put(8'h00);
    exp_head(7'h29);
    exp_data(8'h5A); exp_data(8'h00); exp_data(8'hFF); exp_data(8'h81); exp_data(8'h7E);
    exp_stop(); exp_rsp(4'd0, 16'd5);
    send(mk(1, 0, 7'h29, 0, 0, 0, 0, 3'd0, 32'h0000_0005));
    repeat (40) @(negedge clk);
    check(exp_bus.size() == 4, "R4 waits on empty FIFO", exp_bus.size(), 4);
    tx_put(8'hFF); tx_put(8'h81); tx_put(8'h7E);
    drain();
    check(tx_empty == 1'b1, "R4 pops exactly length", tx_empty, 1);

    // R8 rejected descriptors
    e0 = ev_n;
    exp_rsp(4'd2, 16'd0);
    send(mk(1, 1, 7'h01, 0, 0, 0, 1, 3'd1, 32'h0));
    drain();
    exp_rsp(4'd2, 16'd0);
    send(mk(1, 1, 7'h01, 0, 0, 3'd3, 0, 3'd1, 32'h0));
    drain();
    exp_rsp(4'd2, 16'd0);
    send(mk(1, 0, 7'h01, 1, 0, 0, 0, 3'd0, 32'h0));
    drain();
    check(ev_n == e0, "R8 no bus operation", ev_n - e0, 0);

    // R9 response held while full
    resp_full = 1'b1;
    r0 = resp_n;
    exp_head(7'h02); exp_data(8'h03); exp_stop(); exp_rsp(4'd0, 16'd1);
    send(mk(1, 1, 7'h02, 0, 0, 0, 0, 3'd1, 32'h0000_0003));
    while (exp_bus.size() != 0) @(negedge clk);
    repeat (15) @(negedge clk);
    check(resp_push == 1'b1 && resp_n == r0, "R9 held while full", resp_push, 1);
    check(resp_word[3:0] == 4'd0 && resp_word[31:16] == 16'd1, "R9 held word",
          resp_word, 32'h0001_0000);
    @(negedge clk);
    resp_full = 1'b0;
    drain();
    check(resp_n == r0 + 1, "R9 exactly one push", resp_n - r0, 1);

    // R7 NACK then halt
    nack_next = 1'b1;
    exp_bus.push_back({2'd0, 8'h00, 1'b0});
    exp_bus.push_back({2'd1, 8'hFC, 1'b0});
    exp_stop(); exp_rsp(4'd1, 16'd0);
    send(mk(1, 1, 7'h01, 0, 0, 0, 0, 3'd2, 32'h0000_BEEF));
    while (exp_bus.size() != 0 || exp_resp.size() != 0) @(negedge clk);
    nack_next = 1'b0;
    repeat (10) @(negedge clk);
    check(cmd_ready == 1'b0, "R7 halted blocks commands", cmd_ready, 0);
    e0 = ev_n;
    cmd_word  = mk(1, 1, 7'h03, 0, 0, 0, 0, 3'd1, 32'h0000_0042);
    cmd_valid = 1'b1;
    repeat (10) @(negedge clk);
    check(ev_n == e0 && !bus_req, "R7 no bus op while halted", ev_n - e0, 0);
    exp_head(7'h03); exp_data(8'h42); exp_stop(); exp_rsp(4'd0, 16'd1);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    drain();
    check(cmd_ready == 1'b1, "R7 resumed", cmd_ready, 1);

    // R10 count above four stalls
    r0 = resp_n;
    exp_head(7'h10);
    exp_data(8'h04); exp_data(8'h03); exp_data(8'h02); exp_data(8'h01);
    send(mk(1, 1, 7'h10, 0, 0, 0, 0, 3'd5, 32'h0102_0304));
    while (exp_bus.size() != 0) @(negedge clk);
    e0 = ev_n;
    repeat (30) @(negedge clk);
    check(resp_n == r0 && ev_n == e0, "R10 no stop and no response", resp_n - r0 + ev_n - e0, 0);
    check(cmd_ready == 1'b0 && !bus_req, "R10 stalled", {cmd_ready, bus_req}, 0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R12 ready after second reset", cmd_ready, 1);
    check(exp_bus.size() == 0 && exp_resp.size() == 0, "R2 all expected items seen",
          exp_bus.size() + exp_resp.size(), 0);

    finish_run();
  end
endmodule